// File: doc/BRIEF.md
# Network Receive Buffer with Request/Reply Separation

This block sits on the receive side of a node's network interface. Every cycle it can take one incoming message from a peer node. A message is either a request, which needs local service and usually causes a reply, or a reply to a request this node sent earlier. The two kinds go into two independent queues. A congested request path can therefore never stop replies from being absorbed. Without that separation, two nodes waiting on each other's replies could deadlock.

The block has no ready signal on its input, because it never pushes back on the link. Each peer has a fixed share of request storage. That share is spent by every accepted request and won back by a credit notice sent to the peer when local processing removes the entry. A request from a peer whose share is used up is refused, and the peer receives a negative acknowledgement (NACK) instead.

NACKs and credit notices are held as compact per-peer flags and counters. They share one outbound port with the node's own replies, and notices always take precedence over replies. A blocked outbound path therefore never prevents the block from accepting or refusing input.

Top module: `netin_buffer`

## Requirements
- R1: A reply arriving while the reply queue has a free entry is stored and appears on the reply dequeue port on the next cycle, whatever the state of the request queue.
- R2: The request queue holds up to K entries for each of the PEERS sources, K*PEERS in total, and delivers them in arrival order with their source index and payload.
- R3: A request from a peer is refused when that peer's buffered requests plus its not-yet-returned credits already total K. A refused request is not stored, and a NACK to that peer becomes pending.
- R4: Pending NACKs and credits are kept while `out_ready` is low. Input keeps being accepted or refused in that time, and every pending notice is delivered later.
- R5: Each request dequeued through `rq_pop` produces exactly one credit notice to its source. The notice is `out_kind` 2'b10 with `out_data` zero.
- R6: The outbound port sends NACKs (`out_kind` 2'b01) before credits, and credits before local replies (`out_kind` 2'b00). Within a class, the lowest peer index goes first. `rsp_ready` is high only when no notice is pending and `out_ready` is high.
- R7: An enqueue and a dequeue on the same queue in one cycle leave that queue's occupancy, and the source's held count, unchanged.
- R8: The reply queue holds K entries in order. A reply arriving when the queue is full and not being popped is discarded, and the stored entries stay intact.
- R9: After reset both queues are empty and no notice is pending. A pop on an empty queue has no effect.
- R10: Several refusals of the same peer before delivery merge into a single pending NACK.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Incoming message present this cycle |
| in_is_reply | input | 1 | 1 = reply, 0 = request |
| in_src | input | SRC_W | Index of the sending peer |
| in_data | input | DATA_W | Message payload |
| rq_valid | output | 1 | Request queue head is valid |
| rq_src | output | SRC_W | Source of the request at the head |
| rq_data | output | DATA_W | Payload of the request at the head |
| rq_pop | input | 1 | Remove the request head |
| rp_valid | output | 1 | Reply queue head is valid |
| rp_src | output | SRC_W | Source of the reply at the head |
| rp_data | output | DATA_W | Payload of the reply at the head |
| rp_pop | input | 1 | Remove the reply head |
| rsp_valid | input | 1 | Local processing offers an outbound reply |
| rsp_dst | input | SRC_W | Destination of the local reply |
| rsp_data | input | DATA_W | Payload of the local reply |
| rsp_ready | output | 1 | Local reply is taken this cycle |
| out_valid | output | 1 | Outbound item present |
| out_ready | input | 1 | Transmitter takes the outbound item |
| out_kind | output | 2 | 00 reply, 01 NACK, 10 credit |
| out_dst | output | SRC_W | Destination peer of the outbound item |
| out_data | output | DATA_W | Payload (zero for notices) |

## Verification
The bench sends each peer two more requests than its share while the outbound path is blocked. It then checks that exactly one NACK per peer comes out in index order. A design that failed to merge refusals would emit extra NACKs, and one that stalled would lose replies sent during the blockage. The bench fills the reply queue and sends one more reply, which catches a design that overwrites its oldest entry. An enqueue and a dequeue in the same cycle followed by one more request exposes a held count that drifts upward: such a design would refuse a request it should accept. Credit notices are counted per peer and checked against a waiting local reply, so a lost credit or a reply that jumps the queue shows up.

// File: rtl/netin_pkg.sv
package netin_pkg;

    typedef enum logic [1:0] {
        OUT_REPLY  = 2'b00,
        OUT_NACK   = 2'b01,
        OUT_CREDIT = 2'b10
    } out_kind_e;

    function automatic logic has_room(int unsigned held, int unsigned limit);
        return held < limit;
    endfunction

endpackage

// File: rtl/netin_fifo.sv
module netin_fifo #(
    parameter int WIDTH = 8,
    parameter int DEPTH = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             push,
    input  logic [WIDTH-1:0] wr_data,
    input  logic             pop,
    output logic [WIDTH-1:0] rd_data,
    output logic             empty,
    output logic             full
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [PTR_W-1:0] rd_ptr, wr_ptr;
    logic [CNT_W-1:0] count;
    logic             push_ok, pop_ok;

    assign empty   = (count == '0);
    assign full    = (int'(count) == DEPTH);
    assign pop_ok  = pop && !empty;
    assign push_ok = push && (!full || pop_ok);
    assign rd_data = mem[rd_ptr];

    function automatic logic [PTR_W-1:0] step(logic [PTR_W-1:0] p);
        return (int'(p) == DEPTH - 1) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_ptr <= '0;
            wr_ptr <= '0;
            count  <= '0;
        end else begin
            if (push_ok) begin
                mem[wr_ptr] <= wr_data;
                wr_ptr      <= step(wr_ptr);
            end
            if (pop_ok) rd_ptr <= step(rd_ptr);
            count <= count + CNT_W'(push_ok) - CNT_W'(pop_ok);
        end
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        int'(count) <= DEPTH); // R2
    AST_POP_EMPTY: assert property (@(posedge clk) disable iff (rst)
        (empty && pop && !push) |=> empty); // R9
    AST_SAME_CYCLE: assert property (@(posedge clk) disable iff (rst)
        (push_ok && pop_ok) |=> (count == $past(count))); // R7

endmodule

// File: rtl/netin_peer_ctl.sv
module netin_peer_ctl #(
    parameter int K = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic arrive,
    input  logic deq,
    input  logic nack_taken,
    input  logic credit_taken,
    output logic accept,
    output logic nack_pend,
    output logic credit_pend
);
    localparam int CW = $clog2(K + 1);

    logic [CW-1:0] held_q, cred_q;
    logic          nack_q;
    logic          refuse, cred_dec;

    assign accept      = arrive && netin_pkg::has_room(int'(held_q) + int'(cred_q), K);
    assign refuse      = arrive && !accept;
    assign cred_dec    = credit_taken && (cred_q != '0);
    assign nack_pend   = nack_q;
    assign credit_pend = (cred_q != '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            held_q <= '0;
            cred_q <= '0;
            nack_q <= 1'b0;
        end else begin
            held_q <= held_q + CW'(accept) - CW'(deq);
            cred_q <= cred_q + CW'(deq) - CW'(cred_dec);
            if (refuse)          nack_q <= 1'b1;
            else if (nack_taken) nack_q <= 1'b0;
        end
    end

    AST_RESERVE_BOUND: assert property (@(posedge clk) disable iff (rst)
        (int'(held_q) + int'(cred_q)) <= K); // R3
    AST_DEQ_CREDIT: assert property (@(posedge clk) disable iff (rst)
        deq |=> credit_pend); // R5
    AST_NACK_KEPT: assert property (@(posedge clk) disable iff (rst)
        (nack_q && !nack_taken) |=> nack_q); // R4

endmodule

// File: rtl/netin_out_arb.sv
module netin_out_arb #(
    parameter int PEERS  = 4,
    parameter int SRC_W  = 2,
    parameter int DATA_W = 8
) (
    input  logic [PEERS-1:0]  nack_vec,
    input  logic [PEERS-1:0]  credit_vec,
    input  logic              rsp_valid,
    input  logic [SRC_W-1:0]  rsp_dst,
    input  logic [DATA_W-1:0] rsp_data,
    input  logic              out_ready,
    output logic              rsp_ready,
    output logic              out_valid,
    output logic [1:0]        out_kind,
    output logic [SRC_W-1:0]  out_dst,
    output logic [DATA_W-1:0] out_data,
    output logic [PEERS-1:0]  nack_take,
    output logic [PEERS-1:0]  credit_take
);
    import netin_pkg::*;

    logic             nack_any, credit_any;
    logic [SRC_W-1:0] nack_sel, credit_sel;

    always_comb begin
        nack_sel   = '0;
        credit_sel = '0;
        for (int i = PEERS - 1; i >= 0; i--) begin
            if (nack_vec[i])   nack_sel   = SRC_W'(i);
            if (credit_vec[i]) credit_sel = SRC_W'(i);
        end
        nack_any   = |nack_vec;
        credit_any = |credit_vec;

        out_valid   = nack_any || credit_any || rsp_valid;
        out_data    = '0;
        nack_take   = '0;
        credit_take = '0;
        rsp_ready   = out_ready && !nack_any && !credit_any;
        if (nack_any) begin
            out_kind = OUT_NACK;
            out_dst  = nack_sel;
            nack_take[nack_sel] = out_ready;
        end else if (credit_any) begin
            out_kind = OUT_CREDIT;
            out_dst  = credit_sel;
            credit_take[credit_sel] = out_ready;
        end else begin
            out_kind = OUT_REPLY;
            out_dst  = rsp_dst;
            out_data = rsp_data;
        end
    end

endmodule

// File: rtl/netin_buffer.sv
module netin_buffer #(
    parameter int PEERS  = 4,
    parameter int K      = 2,
    parameter int DATA_W = 8,
    parameter int SRC_W  = (PEERS > 1) ? $clog2(PEERS) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic              in_is_reply,
    input  logic [SRC_W-1:0]  in_src,
    input  logic [DATA_W-1:0] in_data,
    output logic              rq_valid,
    output logic [SRC_W-1:0]  rq_src,
    output logic [DATA_W-1:0] rq_data,
    input  logic              rq_pop,
    output logic              rp_valid,
    output logic [SRC_W-1:0]  rp_src,
    output logic [DATA_W-1:0] rp_data,
    input  logic              rp_pop,
    input  logic              rsp_valid,
    input  logic [SRC_W-1:0]  rsp_dst,
    input  logic [DATA_W-1:0] rsp_data,
    output logic              rsp_ready,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [1:0]        out_kind,
    output logic [SRC_W-1:0]  out_dst,
    output logic [DATA_W-1:0] out_data
);
    import netin_pkg::*;

    localparam int ENTRY_W  = SRC_W + DATA_W;
    localparam int RQ_DEPTH = K * PEERS;

    logic [PEERS-1:0]   accept_vec, nack_vec, credit_vec, nack_take, credit_take;
    logic               rq_empty, rq_full, rp_empty, rp_full;
    logic               is_req, rq_push, rp_push, rq_deq;
    logic [ENTRY_W-1:0] rq_head, rp_head;

    assign is_req  = in_valid && !in_is_reply;
    assign rq_push = (|accept_vec) && !rq_full;
    assign rp_push = in_valid && in_is_reply;
    assign rq_deq  = rq_pop && !rq_empty;

    generate
        for (genvar g = 0; g < PEERS; g++) begin : g_peer
            netin_peer_ctl #(.K(K)) u_peer (
                .clk         (clk),
                .rst         (rst),
                .arrive      (is_req && (in_src == SRC_W'(g))),
                .deq         (rq_deq && (rq_src == SRC_W'(g))),
                .nack_taken  (nack_take[g]),
                .credit_taken(credit_take[g]),
                .accept      (accept_vec[g]),
                .nack_pend   (nack_vec[g]),
                .credit_pend (credit_vec[g])
            );
        end
    endgenerate

    netin_fifo #(.WIDTH(ENTRY_W), .DEPTH(RQ_DEPTH)) u_rq (
        .clk    (clk),
        .rst    (rst),
        .push   (rq_push),
        .wr_data({in_src, in_data}),
        .pop    (rq_pop),
        .rd_data(rq_head),
        .empty  (rq_empty),
        .full   (rq_full)
    );

    netin_fifo #(.WIDTH(ENTRY_W), .DEPTH(K)) u_rp (
        .clk    (clk),
        .rst    (rst),
        .push   (rp_push),
        .wr_data({in_src, in_data}),
        .pop    (rp_pop),
        .rd_data(rp_head),
        .empty  (rp_empty),
        .full   (rp_full)
    );

    assign rq_valid = !rq_empty;
    assign rp_valid = !rp_empty;
    assign {rq_src, rq_data} = rq_head;
    assign {rp_src, rp_data} = rp_head;

    netin_out_arb #(.PEERS(PEERS), .SRC_W(SRC_W), .DATA_W(DATA_W)) u_arb (
        .nack_vec   (nack_vec),
        .credit_vec (credit_vec),
        .rsp_valid  (rsp_valid),
        .rsp_dst    (rsp_dst),
        .rsp_data   (rsp_data),
        .out_ready  (out_ready),
        .rsp_ready  (rsp_ready),
        .out_valid  (out_valid),
        .out_kind   (out_kind),
        .out_dst    (out_dst),
        .out_data   (out_data),
        .nack_take  (nack_take),
        .credit_take(credit_take)
    );

    AST_REPLY_ACCEPT: assert property (@(posedge clk) disable iff (rst)
        (rp_push && !rp_full) |=> rp_valid); // R1
    AST_NACK_PERSIST: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready && out_kind == OUT_NACK) |=> (out_valid && out_kind == OUT_NACK)); // R4
    AST_RSP_BLOCKED: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_kind != OUT_REPLY) |-> !rsp_ready); // R6
    AST_REQ_ROOM: assert property (@(posedge clk) disable iff (rst)
        (|accept_vec) |-> !rq_full); // R2

endmodule

// File: tb/netin_buffer_bench.sv
module netin_buffer_bench;
    localparam int PEERS = 4;
    localparam int K     = 3;
    localparam int DW    = 8;
    localparam int SW    = 2;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          in_valid = 0, in_is_reply = 0, rq_pop = 0, rp_pop = 0;
    logic          rsp_valid = 0, out_ready = 0;
    logic [SW-1:0] in_src = '0, rsp_dst = '0;
    logic [DW-1:0] in_data = '0, rsp_data = '0;
    logic          rq_valid, rp_valid, rsp_ready, out_valid;
    logic [SW-1:0] rq_src, rp_src, out_dst;
    logic [DW-1:0] rq_data, rp_data, out_data;
    logic [1:0]    out_kind;

    int checks = 0;
    int fails  = 0;

    always #2.5 clk = ~clk;

    netin_buffer #(.PEERS(PEERS), .K(K), .DATA_W(DW)) u_netin_buffer (
        .clk(clk), .rst(rst),
        .in_valid(in_valid), .in_is_reply(in_is_reply), .in_src(in_src), .in_data(in_data),
        .rq_valid(rq_valid), .rq_src(rq_src), .rq_data(rq_data), .rq_pop(rq_pop),
        .rp_valid(rp_valid), .rp_src(rp_src), .rp_data(rp_data), .rp_pop(rp_pop),
        .rsp_valid(rsp_valid), .rsp_dst(rsp_dst), .rsp_data(rsp_data), .rsp_ready(rsp_ready),
        .out_valid(out_valid), .out_ready(out_ready), .out_kind(out_kind),
        .out_dst(out_dst), .out_data(out_data)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic send(input bit rep, input int src, input int data);
        in_valid = 1; in_is_reply = rep; in_src = SW'(src); in_data = DW'(data);
        tick();
        in_valid = 0;
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        #(200000 * 5);
        checks++;
        fails++;
        $display("FAIL watchdog: actual 1 expected 0");
        finish_run();
    end

    initial begin
        tick(); tick();
        rst = 0;
        #1;
        // R9: reset state
        chk(!rq_valid && !rp_valid, "R9 reset empty", int'(rq_valid | rp_valid), 0);
        chk(!out_valid, "R9 reset no notice", int'(out_valid), 0);

        // R3/R4/R10: K+2 requests per peer while outbound blocked
        for (int p = 0; p < PEERS; p++)
            for (int i = 0; i < K + 2; i++) send(0, p, p * 16 + i);
        chk(out_valid && out_kind == 2'b01 && out_dst == 0, "R4 NACK held", int'(out_kind), 1);

        // R1/R8: replies with request queue full
        send(1, 1, 8'hA0);
        chk(rp_valid && rp_data == 8'hA0, "R1 reply accepted with full request queue", int'(rp_data), 'hA0);
        for (int j = 1; j <= K; j++) send(1, 1, 8'hA0 + j);

        // R6/R10: NACK drain before local reply
        rsp_valid = 1; rsp_dst = 2'd3; rsp_data = 8'h55;
        out_ready = 1;
        #1;
        for (int p = 0; p < PEERS; p++) begin
            chk(out_valid && out_kind == 2'b01 && int'(out_dst) == p, "R10 one NACK per peer",
                int'(out_dst), p);
            chk(!rsp_ready, "R6 reply held behind NACK", int'(rsp_ready), 0);
            tick();
        end
        chk(out_kind == 2'b00 && out_dst == 3 && out_data == 8'h55 && rsp_ready,
            "R6 reply after notices", int'(out_data), 'h55);
        tick();
        rsp_valid = 0; out_ready = 0;
        #1;
        chk(!out_valid, "R10 no duplicate NACK", int'(out_valid), 0);

        // R2: request order
        for (int p = 0; p < PEERS; p++)
            for (int i = 0; i < K; i++) begin
                chk(rq_valid && int'(rq_src) == p && int'(rq_data) == p * 16 + i,
                    "R2 request order", int'(rq_data), p * 16 + i);
                rq_pop = 1;
                tick();
                rq_pop = 0;
            end
        chk(!rq_valid, "R2 request queue drained", int'(rq_valid), 0);
        rq_pop = 1;
        tick();
        rq_pop = 0;
        chk(!rq_valid && rp_valid && rp_data == 8'hA0, "R9 pop on empty ignored", int'(rp_data), 'hA0);

        // R8: reply order, overflow discarded
        for (int j = 0; j < K; j++) begin
            chk(rp_valid && rp_src == 1 && int'(rp_data) == 'hA0 + j, "R8 reply order",
                int'(rp_data), 'hA0 + j);
            rp_pop = 1;
            tick();
            rp_pop = 0;
        end
        chk(!rp_valid, "R8 extra reply discarded", int'(rp_valid), 0);

        // R5/R6: credit notices, K per peer, ahead of local reply
        rsp_valid = 1; rsp_dst = 2'd2; rsp_data = 8'h66;
        out_ready = 1;
        #1;
        for (int p = 0; p < PEERS; p++)
            for (int j = 0; j < K; j++) begin
                chk(out_valid && out_kind == 2'b10 && int'(out_dst) == p && out_data == 0,
                    "R5 credit notice", int'(out_dst), p);
                chk(!rsp_ready, "R6 reply held behind credit", int'(rsp_ready), 0);
                tick();
            end
        chk(out_kind == 2'b00 && out_data == 8'h66 && rsp_ready, "R6 reply after credits",
            int'(out_data), 'h66);
        tick();
        rsp_valid = 0; out_ready = 0;
        #1;
        chk(!out_valid, "R5 no extra credit", int'(out_valid), 0);

        // R7: simultaneous enqueue and dequeue
        send(0, 2, 8'h70);
        chk(rq_valid && rq_data == 8'h70, "R7 setup", int'(rq_data), 'h70);
        in_valid = 1; in_is_reply = 0; in_src = 2'd2; in_data = 8'h71; rq_pop = 1;
        tick();
        in_valid = 0; rq_pop = 0;
        chk(rq_valid && rq_data == 8'h71, "R7 push and pop together", int'(rq_data), 'h71);
        send(0, 2, 8'h72);
        chk(out_valid && out_kind == 2'b10 && out_dst == 2, "R7 third request accepted",
            int'(out_kind), 2);
        send(0, 2, 8'h73);
        chk(out_valid && out_kind == 2'b01 && out_dst == 2, "R3 share exhausted NACK",
            int'(out_kind), 1);
        chk(rq_data == 8'h71, "R7 head", int'(rq_data), 'h71);
        rq_pop = 1;
        tick();
        rq_pop = 0;
        chk(rq_valid && rq_data == 8'h72, "R7 second entry", int'(rq_data), 'h72);
        rq_pop = 1;
        tick();
        rq_pop = 0;
        chk(!rq_valid, "R3 refused request not stored", int'(rq_valid), 0);

        finish_run();
    end
endmodule